// File: doc/BRIEF.md
# PCI interrupt line router

This block takes level-sensitive interrupt requests from a set of PCI devices and delivers them onto sixteen ISA interrupt request lines for a downstream interrupt controller. Each device input is tagged with the slot the device sits in and the interrupt pin it uses (INTA to INTD as 0 to 3). A fixed, slot-dependent swizzle folds every request onto one of four shared lines, PIRQA to PIRQD. Four byte-wide steering registers then name, for each shared line, the ISA IRQ it drives.

Several shared lines may be steered to the same ISA IRQ, and their levels are ORed there. A steering value of 16 or more leaves its shared line unconnected. Software programs the steering registers through a small byte-wide register port. The ISA level vector is recomputed from the current inputs and steering values and registered once, so it is glitch-free.

Top module: `pirq_router`

## Requirements
- R1: After reset the steering registers for PIRQA, PIRQB, PIRQC and PIRQD hold 10, 10, 11 and 11. They read back at byte addresses 0x60, 0x61, 0x62 and 0x63, in that order, and `isa_irq` is all zero.
- R2: A write to 0x60–0x63 stores all eight bits of `reg_wdata`, including values of 16 or more. `reg_rdata` shows the addressed register combinationally, and any address outside 0x60–0x63 reads 0.
- R3: A steering value below 16 makes its shared line drive the ISA IRQ bit of that number in `isa_irq`.
- R4: A steering value of 16 or more disconnects its shared line, so the line's level reaches no ISA IRQ.
- R5: When several shared lines are steered to one ISA IRQ, that IRQ is the OR of their levels.
- R6: Every ISA IRQ that no active shared line is steered to is driven low.
- R7: Slot 10 always drives PIRQD, slot 11 always drives PIRQB, and slot 12 always drives PIRQC, for any pin.
- R8: For slots 18 to 21 the shared line index is ((slot − 18) + pin) mod 4, with index 0 to 3 meaning PIRQA to PIRQD.
- R9: For every other slot the pin number is used unchanged as the shared line index.
- R10: A shared line is high while any device swizzled onto it is high. It stays high when one of two such devices drops.
- R11: `isa_irq` follows a change of the device inputs or of a steering register on the first rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| dev_level | input | N_DEV | Active-high interrupt level per device |
| dev_slot | input | N_DEV*SLOT_W | Slot number per device, device 0 in the low bits |
| dev_pin | input | N_DEV*2 | Interrupt pin per device (0 = INTA … 3 = INTD) |
| isa_irq | output | 16 | Registered ISA IRQ levels, bit n = IRQ n |

## Verification
Under the reset steering the swizzle cannot be seen, because PIRQA/PIRQB and PIRQC/PIRQD each share an IRQ. The bench therefore first steers the four shared lines to four distinct IRQs. It then sweeps single devices through the fixed slots, through slots 18 to 21 with all four pins, and through pass-through slots. The OR-sharing case needs two shared lines steered to one IRQ and the other line toggled alone. A disconnect is shown by a driven line that leaves the whole vector quiet while its register still reads back the out-of-range value.

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int N_DEV = 8,
  parameter int SLOT_W = 5,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h60
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [7:0]              reg_wdata,
  output logic [7:0]              reg_rdata,
  input  logic [N_DEV-1:0]        dev_level,
  input  logic [N_DEV*SLOT_W-1:0] dev_slot,
  input  logic [N_DEV*2-1:0]      dev_pin,
  output logic [15:0]             isa_irq
);
  localparam int N_LINE = 4;
  localparam int N_ISA = 16;

  logic [7:0] route_q [N_LINE];
  logic [N_LINE-1:0] line_lvl;
  logic [N_ISA-1:0] isa_next;
  logic [1:0] sel;
  logic hit;

  assign sel = reg_addr[1:0];
  assign hit = reg_addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2];
  assign reg_rdata = hit ? route_q[sel] : 8'h00;

  function automatic logic [1:0] swizzle(input logic [SLOT_W-1:0] s, input logic [1:0] p);
    logic [SLOT_W-1:0] off;
    off = s - SLOT_W'(18);
    if (s == SLOT_W'(10)) return 2'd3;
    if (s == SLOT_W'(11)) return 2'd1;
    if (s == SLOT_W'(12)) return 2'd2;
    if (s >= SLOT_W'(18) && s <= SLOT_W'(21)) return off[1:0] + p;
    return p;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_LINE; k++) route_q[k] <= (k < 2) ? 8'd10 : 8'd11;
    end else if (reg_wr && hit) begin
      route_q[sel] <= reg_wdata;
    end
  end

  always_comb begin
    line_lvl = '0;
    for (int d = 0; d < N_DEV; d++)
      if (dev_level[d])
        line_lvl[swizzle(dev_slot[d*SLOT_W +: SLOT_W], dev_pin[d*2 +: 2])] = 1'b1;
  end

  always_comb begin
    isa_next = '0;
    for (int k = 0; k < N_LINE; k++)
      if (route_q[k] < 8'd16 && line_lvl[k])
        isa_next[route_q[k][3:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isa_irq <= '0;
    else        isa_irq <= isa_next;
  end

  AST_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit) |=> (!$stable(reg_addr) || reg_rdata == $past(reg_wdata))); // R2
  AST_QUIET_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_level == '0) |=> (isa_irq == '0)); // R6
  AST_ALL_DISCONNECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q[0] >= 8'd16 && route_q[1] >= 8'd16 && route_q[2] >= 8'd16 && route_q[3] >= 8'd16)
    |=> (isa_irq == '0)); // R4
  AST_FANIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isa_irq) <= N_LINE); // R5
endmodule

// File: tb/pirq_router_tb.sv
module pirq_router_tb_top;
  localparam int N = 8;
  localparam int SW = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [N-1:0] dev_level = '0;
  logic [N*SW-1:0] dev_slot = '0;
  logic [N*2-1:0] dev_pin = '0;
  logic [15:0] isa_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] mroute [4];
  logic [15:0] exp_q [$];
  string tag_q [$];

  always #10 clk = ~clk;

  pirq_router dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_level(dev_level),
    .dev_slot(dev_slot), .dev_pin(dev_pin), .isa_irq(isa_irq));

  function automatic int line_of(int slot, int pin);
    if (slot == 10) return 3;
    if (slot == 11) return 1;
    if (slot == 12) return 2;
    if (slot >= 18 && slot <= 21) return ((slot - 18) + pin) % 4;
    return pin;
  endfunction

  function automatic logic [15:0] model();
    logic [3:0] l = '0;
    logic [15:0] r = '0;
    for (int d = 0; d < N; d++)
      if (dev_level[d]) l[line_of(int'(dev_slot[d*SW +: SW]), int'(dev_pin[d*2 +: 2]))] = 1'b1;
    for (int k = 0; k < 4; k++)
      if (mroute[k] < 16 && l[k]) r[mroute[k][3:0]] = 1'b1;
    return r;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) check(tag_q.pop_front(), isa_irq, exp_q.pop_front());
  end

  task automatic push(string tag);
    exp_q.push_back(model());
    tag_q.push_back(tag);
  endtask

  task automatic set_dev(int d, bit lvl, int slot, int pin, string tag);
    @(negedge clk);
    dev_level[d] = lvl;
    dev_slot[d*SW +: SW] = SW'(slot);
    dev_pin[d*2 +: 2] = 2'(pin);
    push(tag);
  endtask

  task automatic solo(int slot, int pin, string tag);
    @(negedge clk);
    dev_level = '0;
    dev_level[0] = 1'b1;
    dev_slot[SW-1:0] = SW'(slot);
    dev_pin[1:0] = 2'(pin);
    push(tag);
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] v);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
    if (a >= 8'h60 && a <= 8'h63) mroute[a - 8'h60] = v;
    push("R11 output after register write");
  endtask

  task automatic rd_check(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, {8'h00, reg_rdata}, {8'h00, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mroute[0] = 10; mroute[1] = 10; mroute[2] = 11; mroute[3] = 11;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 isa_irq after reset", isa_irq, 16'h0000);
    rd_check(8'h60, 8'd10, "R1 reset PIRQA");
    rd_check(8'h61, 8'd10, "R1 reset PIRQB");
    rd_check(8'h62, 8'd11, "R1 reset PIRQC");
    rd_check(8'h63, 8'd11, "R1 reset PIRQD");
    rd_check(8'h64, 8'd0, "R2 outside address reads zero");
    rd_check(8'h5F, 8'd0, "R2 outside address reads zero");
    solo(18, 0, "R3 reset steering PIRQA to IRQ10");
    solo(20, 0, "R3 reset steering PIRQC to IRQ11");

    wr_reg(8'h60, 8'd3); wr_reg(8'h61, 8'd4);
    wr_reg(8'h62, 8'd5); wr_reg(8'h63, 8'd6);
    wr_reg(8'h70, 8'd9);
    rd_check(8'h60, 8'd3, "R2 readback A");
    rd_check(8'h63, 8'd6, "R2 readback D");
    rd_check(8'h70, 8'd0, "R2 write outside range ignored");

    for (int p = 0; p < 4; p++) begin
      solo(10, p, "R7 slot 10");
      solo(11, p, "R7 slot 11");
      solo(12, p, "R7 slot 12");
    end
    for (int s = 18; s <= 21; s++)
      for (int p = 0; p < 4; p++) solo(s, p, "R8 swizzle slot 18-21");
    for (int p = 0; p < 4; p++) begin
      solo(0, p, "R9 pass-through slot 0");
      solo(5, p, "R9 pass-through slot 5");
      solo(31, p, "R9 pass-through slot 31");
    end

    @(negedge clk); dev_level = '0; push("R6 all quiet");
    set_dev(1, 1, 3, 2, "R10 first device on PIRQC");
    set_dev(2, 1, 19, 1, "R10 second device on PIRQC");
    set_dev(1, 0, 3, 2, "R10 PIRQC stays high");
    set_dev(2, 0, 19, 1, "R10 PIRQC drops");

    wr_reg(8'h60, 8'd7); wr_reg(8'h62, 8'd7);
    set_dev(3, 1, 20, 0, "R5 PIRQC alone on shared IRQ7");
    set_dev(4, 1, 18, 0, "R5 PIRQA and PIRQC on IRQ7");
    set_dev(3, 0, 20, 0, "R5 PIRQA alone on shared IRQ7");
    set_dev(4, 0, 18, 0, "R5 idle");

    wr_reg(8'h61, 8'h10);
    set_dev(5, 1, 11, 0, "R4 value 16 disconnects PIRQB");
    wr_reg(8'h61, 8'hFF);
    rd_check(8'h61, 8'hFF, "R2 all eight bits kept");
    set_dev(5, 0, 11, 0, "R4 idle");
    set_dev(5, 1, 11, 3, "R4 value 255 disconnects PIRQB");
    wr_reg(8'h61, 8'd15);
    check("R3 IRQ15 reconnect", isa_irq, 16'h0000);
    @(negedge clk); push("R3 PIRQB on IRQ15");

    @(negedge clk);
    dev_level = '0;
    #8;
    check("R11 no change before edge", isa_irq, 16'h8000);
    push("R11 change after edge");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule